// File: doc/BRIEF.md
# Programmable Pipelined March-Test Engine

This block is a memory self-test engine. Software or a test controller loads a short program of 6-bit instructions into a small code store. Then a start pulse makes the engine step through that program with a three-stage pipeline (fetch, decode, issue) and apply march-style sequences to a 256-word by 16-bit SRAM. Each march element is a run of data operations at the current location. An address instruction sets the direction of travel and the first location. A backward jump repeats the element at the next location until the end of the range is reached.

Read data arrives two cycles after the request. A comparator checks it against the background pattern that the same instruction produced, and it holds a fail flag that stays set until the next start. The engine stops on an invalid instruction or when it runs past the last code entry. It signals completion once the last outstanding read has been compared.

Instruction fields (bit 0 is the least significant): bits [5:4] give the kind (00 data operation, 01 address, 10 jump, 11 halt). Bit 0 is an enable for every kind except halt.

Top module: `mbist_pipe_ctrl`

## Requirements
- R1: A data-operation instruction with bit 0 set issues exactly one access at the current address, writing when bit 1 is 1 and reading when it is 0, with the data word on mem_wdata. With bit 0 clear it issues no access.
- R2: Bits [3:2] of a data operation choose the 16-bit background: 00 gives 0x0000, 01 gives 0x5555, 10 gives 0xAAAA and 11 gives 0xFFFF.
- R3: An enabled address instruction sets the direction from bit 1 (1 up, 0 down) and moves the address to 0 for up or 255 for down. A disabled one changes neither.
- R4: An enabled jump whose address is not at its end (255 going up, 0 going down) steps the address once in the current direction and continues at the instruction that is bits [2:1] entries before the jump. At the end address it falls through and the address returns to the start value of the current direction. A disabled jump does nothing.
- R5: The first instruction's access appears on the memory port in the third cycle after the start edge. Instructions issue one per cycle, and a taken jump adds exactly one dead cycle, because the wrong-path fetch is flushed.
- R6: A halt-kind instruction, or fetching past code entry 15, stops execution. done rises only after every issued read has been compared. No access is issued while done is high, and done stays high until the next start.
- R7: Each read is compared with its background two cycles after issue. Any mismatch sets fail, which stays set until the next start. Writes are never compared.
- R8: start clears fail and done, restarts execution at code entry 0, and sets the address to 0 with direction up.
- R9: After reset, mem_ce, done and fail are low.
- R10: A write on the code port with cm_we high stores cm_wdata at entry cm_addr, and later runs use the stored program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run of the loaded program |
| done | output | 1 | Run finished and all reads checked |
| cm_we | input | 1 | Code store write enable |
| cm_addr | input | 4 | Code store entry |
| cm_wdata | input | 6 | Instruction to store |
| mem_ce | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 8 | Memory word address |
| mem_wdata | output | 16 | Write data / background of the access |
| mem_rdata | input | 16 | Read data, valid two cycles after the read request |
| fail | output | 1 | Sticky compare mismatch |

## Verification
The hardest situation to reach from the ports is a read that returns in the same window as a taken jump. The flushed fetch and the delayed compare then overlap, so a misaligned compare stage would check the wrong address. Random march programs with one to three elements of one or two operations create this overlap on every location. A single stuck bit placed at a random address then tests whether fail tracks the bench's own replay of the program. Every issued access is also matched against the replay for its exact cycle, kind, address and data, which exposes any change in jump timing or flushing.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int INS_W  = 6;
    localparam int PC_W   = 4;
    localparam int RD_LAT = 2;

    typedef enum logic [1:0] {
        K_ALG = 2'b00,
        K_ADR = 2'b01,
        K_JMP = 2'b10,
        K_BAD = 2'b11
    } ins_kind_e;

    localparam logic [INS_W-1:0] INS_HALT = 6'b110000;

    typedef struct packed {
        logic              act;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } mem_op_t;

    function automatic logic [DATA_W-1:0] bg_word(input logic [1:0] sel);
        logic [DATA_W-1:0] w;
        case (sel)
            2'b00:   w = '0;
            2'b01:   w = {(DATA_W/2){2'b01}};
            2'b10:   w = {(DATA_W/2){2'b10}};
            default: w = '1;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/mbist_code_mem.sv
module mbist_code_mem #(
    parameter int AW = 4,
    parameter int W  = 6
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_addr] <= wr_data;
    end

    assign rd_data = store[rd_addr];

endmodule

// File: rtl/mbist_addr_gen.sv
module mbist_addr_gen #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          init,
    input  logic          set_dir,
    input  logic          dir_in,
    input  logic          step,
    input  logic          wrap,
    output logic [AW-1:0] addr,
    output logic          up,
    output logic          at_end
);
    localparam logic [AW-1:0] TOP = {AW{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || init) begin
            addr <= '0;
            up   <= 1'b1;
        end else if (set_dir) begin
            up   <= dir_in;
            addr <= dir_in ? '0 : TOP;
        end else if (step) begin
            addr <= up ? addr + 1'b1 : addr - 1'b1;
        end else if (wrap) begin
            addr <= up ? '0 : TOP;
        end
    end

    assign at_end = up ? (addr == TOP) : (addr == '0);

    // R3 / R4: the address only moves by one or jumps to a start value
    a_r4_addr_moves: assert property (@(posedge clk) disable iff (rst)
        !$stable(addr) |-> (addr == $past(addr) + 1'b1 || addr == $past(addr) - 1'b1
                            || addr == '0 || addr == TOP));

endmodule

// File: rtl/mbist_resp_cmp.sv
module mbist_resp_cmp #(
    parameter int DW  = 16,
    parameter int LAT = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          req,
    input  logic [DW-1:0] exp_in,
    input  logic [DW-1:0] rdata,
    output logic          fail,
    output logic          pend
);
    logic [LAT-1:0] v;
    logic [DW-1:0]  e [LAT];

    for (genvar g = 0; g < LAT; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst || clr) v[g] <= 1'b0;
                else            v[g] <= req;
                e[g] <= exp_in;
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst || clr) v[g] <= 1'b0;
                else            v[g] <= v[g-1];
                e[g] <= e[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr)                             fail <= 1'b0;
        else if (v[LAT-1] && rdata != e[LAT-1])     fail <= 1'b1;
    end

    assign pend = |v;

    // R7: fail is sticky until cleared
    a_r7_fail_sticky: assert property (@(posedge clk) disable iff (rst)
        (fail && !clr) |=> fail);

    // R7: a new failure needs a compare in the last stage
    a_r7_fail_needs_read: assert property (@(posedge clk) disable iff (rst)
        (!fail && !v[LAT-1]) |=> !fail);

endmodule

// File: rtl/mbist_pipe_ctrl.sv
module mbist_pipe_ctrl
    import mbist_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              done,
    input  logic              cm_we,
    input  logic [PC_W-1:0]   cm_addr,
    input  logic [INS_W-1:0]  cm_wdata,
    output logic              mem_ce,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              fail
);
    logic              running, halted, done_q;
    logic [PC_W:0]     pc, ir_pc;
    logic              ir_v;
    logic [INS_W-1:0]  ir, cm_q;
    mem_op_t           ex_q, ex_n;
    ins_kind_e         kind;
    logic              dec_on, is_halt, set_dir, jmp_en, take, wrap;
    logic [ADDR_W-1:0] ag_addr;
    logic              ag_up, ag_end, pend;

    mbist_code_mem #(.AW(PC_W), .W(INS_W)) i_code (
        .clk(clk), .wr_en(cm_we), .wr_addr(cm_addr), .wr_data(cm_wdata),
        .rd_addr(pc[PC_W-1:0]), .rd_data(cm_q)
    );

    // decode stage
    always_comb begin
        kind    = ins_kind_e'(ir[5:4]);
        dec_on  = running && ir_v;
        is_halt = dec_on && kind == K_BAD;
        set_dir = dec_on && kind == K_ADR && ir[0];
        jmp_en  = dec_on && kind == K_JMP && ir[0];
        take    = jmp_en && !ag_end;
        wrap    = jmp_en && ag_end;
        ex_n.act  = dec_on && kind == K_ALG && ir[0];
        ex_n.wr   = ir[1];
        ex_n.addr = ag_addr;
        ex_n.data = bg_word(ir[3:2]);
    end

    mbist_addr_gen #(.AW(ADDR_W)) i_agen (
        .clk(clk), .rst(rst), .init(start), .set_dir(set_dir), .dir_in(ir[1]),
        .step(take), .wrap(wrap), .addr(ag_addr), .up(ag_up), .at_end(ag_end)
    );

    // fetch stage, redirect and halt control
    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            halted  <= 1'b0;
            done_q  <= 1'b0;
            ir_v    <= 1'b0;
            ir      <= '0;
            pc      <= '0;
            ir_pc   <= '0;
            ex_q    <= '0;
        end else if (start) begin
            running <= 1'b1;
            halted  <= 1'b0;
            done_q  <= 1'b0;
            ir_v    <= 1'b0;
            pc      <= '0;
            ex_q    <= '0;
        end else begin
            ex_q <= ex_n;
            if (is_halt) begin
                running <= 1'b0;
                halted  <= 1'b1;
                ir_v    <= 1'b0;
            end else if (take) begin
                pc   <= ir_pc - (PC_W+1)'(ir[2:1]);
                ir_v <= 1'b0;
            end else if (running) begin
                ir    <= pc[PC_W] ? INS_HALT : cm_q;
                ir_pc <= pc;
                pc    <= pc + 1'b1;
                ir_v  <= 1'b1;
            end
            if (halted && !ex_q.act && !pend) done_q <= 1'b1;
        end
    end

    // issue stage and response check
    mbist_resp_cmp #(.DW(DATA_W), .LAT(RD_LAT)) i_cmp (
        .clk(clk), .rst(rst), .clr(start), .req(ex_q.act && !ex_q.wr),
        .exp_in(ex_q.data), .rdata(mem_rdata), .fail(fail), .pend(pend)
    );

    assign mem_ce    = ex_q.act;
    assign mem_we    = ex_q.wr;
    assign mem_addr  = ex_q.addr;
    assign mem_wdata = ex_q.data;
    assign done      = done_q;

    // R6: no access while finished
    a_r6_quiet_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_ce);

    // R8: start clears status and the issue stage
    a_r8_start_clears: assert property (@(posedge clk) disable iff (rst)
        start |=> (!fail && !done && !mem_ce));

    // R5: a taken jump flushes the wrong-path fetch
    a_r5_flush: assert property (@(posedge clk) disable iff (rst)
        (take && !start) |=> !ir_v);

    // R6: done never rises with a read still pending
    a_r6_done_after_drain: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (!pend && !running));

    // R4: direction held across a jump
    a_r4_dir_kept: assert property (@(posedge clk) disable iff (rst)
        (jmp_en && !start) |=> $stable(ag_up));

endmodule

// File: tb/test_mbist_pipe_ctrl.sv
module test_mbist_pipe_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NMAX = 4096;

    logic clk = 1'b0;
    logic rst, start, cm_we, done, mem_ce, mem_we, fail;
    logic [3:0]  cm_addr;
    logic [5:0]  cm_wdata;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata, mem_rdata, p1;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbist_pipe_ctrl i_mbist_pipe_ctrl (
        .clk(clk), .rst(rst), .start(start), .done(done),
        .cm_we(cm_we), .cm_addr(cm_addr), .cm_wdata(cm_wdata),
        .mem_ce(mem_ce), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .fail(fail)
    );

    int n_chk = 0, n_bad = 0;
    logic [15:0] sram [256];
    logic [15:0] ref_mem [256];
    logic [5:0]  prog [16];
    int          f_on = 0, f_addr = 0;
    logic [15:0] sa0 = '0, sa1 = '0;

    int          exp_cyc [NMAX];
    logic        exp_we  [NMAX];
    int          exp_a   [NMAX];
    logic [15:0] exp_d   [NMAX];
    int          n_exp;
    logic        exp_fail;

    function automatic logic [15:0] rd_fault(int a, logic [15:0] v);
        if (f_on != 0 && a == f_addr) return (v & ~sa0) | sa1;
        return v;
    endfunction

    // SRAM under test with two-cycle read latency and optional stuck bits
    always @(posedge clk) begin
        if (mem_ce && mem_we) sram[mem_addr] <= mem_wdata;
        if (mem_ce && !mem_we) p1 <= rd_fault(int'(mem_addr), sram[mem_addr]);
        mem_rdata <= p1;
    end

    task automatic check(bit ok, string req, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic logic [15:0] bgf(logic [1:0] s);
        case (s)
            2'd0: return 16'h0000;
            2'd1: return 16'h5555;
            2'd2: return 16'hAAAA;
            default: return 16'hFFFF;
        endcase
    endfunction

    function automatic logic [5:0] i_op(bit wr, logic [1:0] bg, bit en = 1);
        return {2'b00, bg, wr, en};
    endfunction
    function automatic logic [5:0] i_adr(bit up, bit en = 1);
        return {2'b01, 2'b00, up, en};
    endfunction
    function automatic logic [5:0] i_jmp(logic [1:0] k, bit en = 1);
        return {2'b10, 1'b0, k, en};
    endfunction
    localparam logic [5:0] I_END = 6'b110000;

    // replay of the program per the requirements
    task automatic model();
        int pc = 0, a = 0, up = 1, slot = 0, guard = 0;
        bit stop = 0;
        logic [5:0] ins;
        logic [15:0] v;
        n_exp = 0;
        exp_fail = 0;
        while (!stop && guard < 100000) begin
            guard++;
            if (pc < 0 || pc > 15) begin
                stop = 1;
            end else begin
                ins = prog[pc];
                case (ins[5:4])
                    2'b11: stop = 1;
                    2'b00: begin
                        if (ins[0]) begin
                            exp_cyc[n_exp] = slot + 2;
                            exp_we[n_exp]  = ins[1];
                            exp_a[n_exp]   = a;
                            exp_d[n_exp]   = bgf(ins[3:2]);
                            if (ins[1]) ref_mem[a] = bgf(ins[3:2]);
                            else begin
                                v = rd_fault(a, ref_mem[a]);
                                if (v != bgf(ins[3:2])) exp_fail = 1;
                            end
                            n_exp++;
                        end
                        slot++; pc++;
                    end
                    2'b01: begin
                        if (ins[0]) begin up = ins[1]; a = up ? 0 : 255; end
                        slot++; pc++;
                    end
                    default: begin
                        if (ins[0] && !(up ? a == 255 : a == 0)) begin
                            a = up ? a + 1 : a - 1;
                            pc = pc - int'(ins[2:1]);
                            slot += 2;
                        end else begin
                            if (ins[0]) a = up ? 0 : 255;
                            pc++; slot++;
                        end
                    end
                endcase
            end
        end
    endtask

    task automatic load_prog();
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            cm_we = 1'b1; cm_addr = 4'(i); cm_wdata = prog[i];
        end
        @(negedge clk);
        cm_we = 1'b0;
    endtask

    task automatic init_mem();
        for (int i = 0; i < 256; i++) begin
            logic [15:0] r;
            r = 16'($urandom);
            sram[i] = r;
            ref_mem[i] = r;
        end
    endtask

    task automatic run(string tag);
        int idx = 0, n_obs = 0, mism = 0, m_idx = -1;
        init_mem();
        load_prog();   // R10: program goes in through the code port
        model();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(fail == 0 && done == 0, "R8", {tag, " status cleared by start"}, {fail, done}, 0);
        while (!done && idx < 20000) begin
            if (mem_ce) begin
                if (n_obs >= n_exp || idx != exp_cyc[n_obs] || mem_we != exp_we[n_obs]
                    || int'(mem_addr) != exp_a[n_obs] || mem_wdata != exp_d[n_obs]) begin
                    if (m_idx < 0) m_idx = n_obs;
                    mism++;
                end
                n_obs++;
            end
            idx++;
            @(negedge clk);
        end
        check(done == 1, "R6", {tag, " run completes"}, done, 1);
        check(n_obs == n_exp, "R1", {tag, " access count"}, n_obs, n_exp);
        // R3 R4 R5 R10: every access at its cycle, kind, address and data
        check(mism == 0, "R5", {tag, " access trace (R3/R4/R10) first bad index"}, m_idx, -1);
        check(fail == exp_fail, "R7", {tag, " fail flag"}, fail, exp_fail);
        begin
            int quiet = 1;
            repeat (6) begin
                @(negedge clk);
                if (mem_ce || !done) quiet = 0;
            end
            check(quiet == 1, "R6", {tag, " done held with no access"}, quiet, 1);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 16; i++) prog[i] = I_END;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; start = 1'b0; cm_we = 1'b0; cm_addr = '0; cm_wdata = '0;
        mem_rdata = '0; p1 = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(mem_ce == 0 && done == 0 && fail == 0, "R9", "reset outputs", {mem_ce, done, fail}, 0);

        // march: up write 0; up read 0 write 1; down read 1 write 0
        clear_prog();
        prog[0] = i_adr(1); prog[1] = i_op(1, 2'd0); prog[2] = i_jmp(2'd1);
        prog[3] = i_adr(1); prog[4] = i_op(0, 2'd0); prog[5] = i_op(1, 2'd3); prog[6] = i_jmp(2'd2);
        prog[7] = i_adr(0); prog[8] = i_op(0, 2'd3); prog[9] = i_op(1, 2'd0); prog[10] = i_jmp(2'd2);
        run("R1 march clean");
        f_on = 1; f_addr = 37; sa0 = 16'h0100; sa1 = '0;
        run("R7 march stuck-at-0");
        f_addr = 0; sa0 = '0; sa1 = 16'h8000;
        run("R7 march stuck-at-1 at lowest word");

        // R2: 0x5555 hides a stuck-1 on bit 0, 0xAAAA reveals it
        f_addr = 200; sa0 = '0; sa1 = 16'h0001;
        clear_prog();
        prog[0] = i_adr(0); prog[1] = i_op(1, 2'd1); prog[2] = i_op(0, 2'd1); prog[3] = i_jmp(2'd2);
        run("R2 background 0x5555");
        prog[1] = i_op(1, 2'd2); prog[2] = i_op(0, 2'd2);
        run("R2 background 0xAAAA");

        // R7: writes only, with a fault present, never fail
        clear_prog();
        prog[0] = i_adr(1); prog[1] = i_op(1, 2'd2); prog[2] = i_jmp(2'd1);
        run("R7 write only");
        f_on = 0;

        // R1 R3 R4: disabled instructions mixed in; run past end of code (R6)
        for (int i = 0; i < 16; i++) prog[i] = i_op(1, 2'd3, 0);
        prog[0] = i_adr(0); prog[1] = i_adr(1, 0); prog[2] = i_op(1, 2'd1);
        prog[3] = i_jmp(2'd1, 0); prog[4] = i_op(0, 2'd1); prog[5] = i_jmp(2'd3);
        prog[6] = i_op(0, 2'd1);
        run("R4 disabled fields and end of code");

        // random march programs
        for (int t = 0; t < 6; t++) begin
            int p = 0;
            int ne = 1 + int'($urandom_range(2));
            clear_prog();
            for (int e = 0; e < ne; e++) begin
                int no = 1 + int'($urandom_range(1));
                prog[p++] = i_adr(1'($urandom_range(1)));
                for (int o = 0; o < no; o++)
                    prog[p++] = i_op(1'($urandom_range(1)), 2'($urandom_range(3)));
                prog[p++] = i_jmp(2'(no));
            end
            f_on = int'($urandom_range(1));
            f_addr = int'($urandom_range(255));
            sa0 = 16'(1) << $urandom_range(15);
            sa1 = 16'(1) << $urandom_range(15);
            if (sa0 == sa1) sa1 = '0;
            run("R4 random march");
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule